// File: doc/BRIEF.md
# Rate-Tolerant Gigabit Fiber Receive Ordered-Set Tracker

This block follows the configuration and idle traffic of a 1000BASE-X receive path one decoded code group per cycle. It recognises configuration ordered sets and assembles their 16-bit payload. It recognises idle ordered sets. It reports each kind of set, and invalid sequences, as receive indications for an auto-negotiation engine. When the transmit side is in data mode, it also decides whether a non-idle code group is a real start of packet or a false carrier.

The code groups reach it through a clock-compensation buffer. That buffer may duplicate or drop the leading two code groups of a configuration set, or a whole idle set, and it flags each such edit. The standard receive sequence would read these edits as protocol violations and restart negotiation. This block adds transitions keyed on the buffer's inserted and deleted flags so that edited streams are still followed cleanly.

The upstream synchronizer declares sync one cycle later than the code group it belongs to. To line the two up, every data and status input passes through SYNC_LAG register stages before the sequence logic sees it, while the sync status is used as it arrives. Packet reception beyond the start-of-packet decision is handled elsewhere.

Top module: `rx_cfg_idle_fsm`

## Requirements
- R1: While rst_n is low at a clock edge, all outputs go to zero: receiving, rx_dv, rx_er, rxd, the three indications and cfg_reg.
- R2: Sync status low forces the link-failed state, in which every indication stays low. Once sync returns, the block first moves to a wait state. It resumes tracking only on the first comma (byte 0xBC with rx_ctrl high) flagged even that arrives in that wait state.
- R3: After a comma, a following data byte (rx_ctrl and rx_code_err low) of 0xB5 or 0x42 opens a configuration set. Any other data byte opens an idle set, and ind_idle is high for the cycle spent in that idle state.
- R4: The third and fourth bytes of a configuration set are captured as the low and then the high byte of cfg_reg. cfg_reg changes only as the set completes, and ind_cfg is high in that same cycle.
- R5: In the second byte position of a configuration set, any code group without a code error, with rm_ins high and rm_del low, keeps the block in that position. Otherwise a control or errored byte gives an invalid sequence. Otherwise the byte is taken as the low config byte.
- R6: After the high config byte, a data byte with rm_del high and rm_ins low is taken as a new low config byte. Otherwise an even comma starts a new set. Anything else, including a data byte with both buffer flags high, gives an invalid sequence.
- R7: In the idle state, a data byte with rm_del high, rm_ins low and rx_even high is taken as the low config byte of a truncated set. In configuration or idle mode, any other non-comma byte gives an invalid sequence.
- R8: In the invalid state, ind_invalid is high only when xmit_mode was 0 (configuration; 1 is idle, 2 is data). The state is left for comma tracking only on a comma flagged even.
- R9: In data mode (xmit_mode 2), a non-comma byte in the idle state with carrier_in high is judged for a start of packet. For 0xFB with rx_ctrl high, receiving and rx_dv are high and rxd is 0x55 for one cycle. With carrier_in low, the byte is taken as the start of a new comma-led sequence and receiving stays low.
- R10: Any other carrier byte leads, one cycle after the judgement, to false-carrier reporting: rx_er and receiving high and rxd 0x0E. This lasts exactly one cycle when the next byte is an even comma.
- R11: Data and status inputs reach the sequence logic SYNC_LAG cycles after they are driven, while sync_ok acts without delay. A sync drop driven alongside a byte therefore disqualifies the byte driven SYNC_LAG cycles earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Code-group clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_byte | input | 8 | Decoded code-group value |
| rx_ctrl | input | 1 | High when the code group is a control (K) group |
| rx_code_err | input | 1 | High on a disparity error or code violation |
| rx_even | input | 1 | High when the code group sits on an even position |
| sync_ok | input | 1 | Synchronization status, arriving SYNC_LAG cycles late |
| xmit_mode | input | 2 | 0 configuration, 1 idle, 2 data |
| carrier_in | input | 1 | Carrier seen on this code group |
| rm_ins | input | 1 | Compensation buffer inserted this code group |
| rm_del | input | 1 | Compensation buffer deleted code groups just before this one |
| receiving | output | 1 | Reception in progress |
| rx_dv | output | 1 | Start-of-packet data valid |
| rx_er | output | 1 | Receive error (false carrier) |
| rxd | output | 8 | Receive data byte toward the MAC side |
| ind_cfg | output | 1 | Configuration set received |
| ind_idle | output | 1 | Idle set received |
| ind_invalid | output | 1 | Invalid sequence in configuration mode |
| cfg_reg | output | 16 | Last received configuration word |

## Verification
The bench builds the block with the default SYNC_LAG of 1, so each decision shows at the outputs two edges after its byte is driven. This single lag also makes it observable whether a sync drop disqualifies the earlier byte rather than the one driven with it. Directed streams cover the duplicated and the dropped leading pair of a configuration set, a set truncated right after an idle, and the same edits with wrong flags or odd position. Data-mode streams cover start of packet, false carrier and a missing carrier.

// File: rtl/rxsm_pkg.sv
// Shared types and code-group constants for the rate-tolerant receive tracker.
// Assumes 8-bit decoded code groups.
package rxsm_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        XM_CONFIG = 2'd0,
        XM_IDLE   = 2'd1,
        XM_DATA   = 2'd2
    } xmit_e;

    typedef enum logic [3:0] {
        S_LINK_FAILED = 4'd0,
        S_WAIT_K      = 4'd1,
        S_GOT_K       = 4'd2,
        S_CFG_B       = 4'd3,
        S_CFG_LO      = 4'd4,
        S_CFG_HI      = 4'd5,
        S_IDLE_D      = 4'd6,
        S_INVALID     = 4'd7,
        S_CARRIER     = 4'd8,
        S_FALSE_CAR   = 4'd9
    } rx_state_e;

    localparam logic [BYTE_W-1:0] CG_COMMA    = 8'hBC;
    localparam logic [BYTE_W-1:0] CG_CFG_A    = 8'hB5;
    localparam logic [BYTE_W-1:0] CG_CFG_B    = 8'h42;
    localparam logic [BYTE_W-1:0] CG_SOF      = 8'hFB;
    localparam logic [BYTE_W-1:0] RXD_FALSE   = 8'h0E;
    localparam logic [BYTE_W-1:0] RXD_PREAMB  = 8'h55;
endpackage

// File: rtl/rxsm_lag.sv
// Delay line of LAG register stages for a W-bit bundle.
// Assumes synchronous active-low reset; LAG of zero gives a plain wire.
module rxsm_lag #(
    parameter int LAG = 1,
    parameter int W   = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    generate
        if (LAG == 0) begin : g_wire
            assign d_out = d_in;
        end else begin : g_regs
            logic [W-1:0] stage_q [LAG];
            // Shift the bundle one stage per clock.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < LAG; i++) stage_q[i] <= '0;
                end else begin
                    stage_q[0] <= d_in;
                    for (int i = 1; i < LAG; i++) stage_q[i] <= stage_q[i-1];
                end
            end
            assign d_out = stage_q[LAG-1];
        end
    endgenerate
endmodule

// File: rtl/rxsm_classify.sv
// Combinational classification of one decoded code group.
// Assumes the code-error flag overrides any value carried in the byte.
module rxsm_classify
    import rxsm_pkg::*;
(
    input  logic [BYTE_W-1:0] cg,
    input  logic              is_k,
    input  logic              err,
    output logic              comma,
    output logic              cfg_char,
    output logic              sof,
    output logic              data_ok,
    output logic              valid
);
    // Decode the code-group categories used by the sequence logic.
    always_comb begin
        valid    = !err;
        data_ok  = !err && !is_k;
        comma    = valid && is_k && (cg == CG_COMMA);
        sof      = valid && is_k && (cg == CG_SOF);
        cfg_char = data_ok && ((cg == CG_CFG_A) || (cg == CG_CFG_B));
    end
endmodule

// File: rtl/rxsm_cfg_capture.sv
// Assembles the 16-bit configuration word from two captured bytes.
// Assumes the low byte load always precedes the high byte load.
module rxsm_cfg_capture
    import rxsm_pkg::*;
#(
    localparam int CFG_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] cg,
    input  logic              load_lo,
    input  logic              load_hi,
    output logic [CFG_W-1:0]  cfg_word
);
    logic [BYTE_W-1:0] lo_q;

    // Stage the low byte, then publish the whole word on the high byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q     <= '0;
            cfg_word <= '0;
        end else begin
            if (load_lo) lo_q <= cg;
            if (load_hi) cfg_word <= {cg, lo_q};
        end
    end
endmodule

// File: rtl/rxsm_fsm.sv
// Receive sequence state machine with compensation-buffer-aware transitions.
// Assumes inputs are already lined up with sync_ok; sync_ok low overrides all.
module rxsm_fsm
    import rxsm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_ok,
    input  xmit_e             xmit,
    input  logic              even,
    input  logic              carrier,
    input  logic              ins,
    input  logic              del,
    input  logic              comma,
    input  logic              cfg_char,
    input  logic              sof,
    input  logic              data_ok,
    input  logic              valid,
    output logic              load_lo,
    output logic              load_hi,
    output logic              receiving,
    output logic              rx_dv,
    output logic              rx_er,
    output logic [BYTE_W-1:0] rxd,
    output logic              ind_cfg,
    output logic              ind_idle,
    output logic              ind_invalid
);
    rx_state_e st_q, st_nx;
    xmit_e     mode_q;
    logic      sof_q;
    logic      del_only;

    assign del_only = data_ok && del && !ins;

    // Next-state selection, including the buffer-edit tolerant paths.
    always_comb begin
        st_nx   = st_q;
        load_lo = 1'b0;
        load_hi = 1'b0;
        if (!sync_ok) begin
            st_nx = S_LINK_FAILED;
        end else begin
            unique case (st_q)
                S_LINK_FAILED: st_nx = S_WAIT_K;
                S_WAIT_K:      if (comma && even) st_nx = S_GOT_K;
                S_GOT_K: begin
                    if (cfg_char)                         st_nx = S_CFG_B;
                    else if (xmit != XM_DATA && !data_ok) st_nx = S_INVALID;
                    else                                  st_nx = S_IDLE_D;
                end
                S_CFG_B: begin
                    if (valid && ins && !del) st_nx = S_CFG_B;
                    else if (!data_ok)        st_nx = S_INVALID;
                    else begin st_nx = S_CFG_LO; load_lo = 1'b1; end
                end
                S_CFG_LO: begin
                    if (data_ok) begin st_nx = S_CFG_HI; load_hi = 1'b1; end
                    else               st_nx = S_INVALID;
                end
                S_CFG_HI: begin
                    if (del_only)           begin st_nx = S_CFG_LO; load_lo = 1'b1; end
                    else if (comma && even) st_nx = S_GOT_K;
                    else                    st_nx = S_INVALID;
                end
                S_IDLE_D: begin
                    if (del_only && even)     begin st_nx = S_CFG_LO; load_lo = 1'b1; end
                    else if (comma)           st_nx = S_GOT_K;
                    else if (xmit == XM_DATA) st_nx = carrier ? S_CARRIER : S_GOT_K;
                    else                      st_nx = S_INVALID;
                end
                S_CARRIER:   st_nx = sof_q ? S_WAIT_K : S_FALSE_CAR;
                S_FALSE_CAR: if (comma && even) st_nx = S_GOT_K;
                S_INVALID:   if (comma && even) st_nx = S_GOT_K;
                default:     st_nx = S_LINK_FAILED;
            endcase
        end
    end

    // State, transmit-mode and start-of-packet registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= S_LINK_FAILED;
            mode_q <= XM_CONFIG;
            sof_q  <= 1'b0;
        end else begin
            st_q   <= st_nx;
            mode_q <= xmit;
            sof_q  <= (st_nx == S_CARRIER) && sof;
        end
    end

    // Moore outputs decoded from the current state.
    always_comb begin
        rx_dv       = (st_q == S_CARRIER) && sof_q;
        rx_er       = (st_q == S_FALSE_CAR);
        receiving   = (st_q == S_CARRIER) || (st_q == S_FALSE_CAR) ||
                      ((st_q == S_INVALID) && (mode_q == XM_DATA));
        rxd         = rx_dv ? RXD_PREAMB : (rx_er ? RXD_FALSE : '0);
        ind_cfg     = (st_q == S_CFG_HI);
        ind_idle    = (st_q == S_IDLE_D);
        ind_invalid = (st_q == S_INVALID) && (mode_q == XM_CONFIG);
    end

    // R2: sync loss always lands in the link-failed state.
    a_r2_sync_loss: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_ok |=> st_q == S_LINK_FAILED);
    // R5: an inserted code group in the second set position is absorbed.
    a_r5_insert_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_CFG_B && sync_ok && valid && ins && !del) |=> st_q == S_CFG_B);
    // R6: a deleted leading pair after the high byte restarts at the low byte.
    a_r6_delete_return: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_CFG_HI && sync_ok && data_ok && del && !ins) |=> st_q == S_CFG_LO);
    // R7: a truncated set after an idle is picked up at the low byte.
    a_r7_idle_delete: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_IDLE_D && sync_ok && data_ok && del && !ins && even) |=> st_q == S_CFG_LO);
    // R9: data valid only while receiving.
    a_r9_dv_receiving: assert property (@(posedge clk) disable iff (!rst_n)
        rx_dv |-> receiving);
    // R10: false-carrier error carries its marker byte.
    a_r10_false_car_rxd: assert property (@(posedge clk) disable iff (!rst_n)
        rx_er |-> (rxd == RXD_FALSE && receiving));
endmodule

// File: rtl/rx_cfg_idle_fsm.sv
// Top: lines inputs up with a late sync status, classifies each code group,
// runs the receive sequence and assembles the configuration word.
// Assumes sync_ok arrives SYNC_LAG cycles after the code group it qualifies.
module rx_cfg_idle_fsm
    import rxsm_pkg::*;
#(
    parameter int SYNC_LAG = 1,
    localparam int CFG_W   = 2 * BYTE_W,
    localparam int BUND_W  = BYTE_W + 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_ctrl,
    input  logic              rx_code_err,
    input  logic              rx_even,
    input  logic              sync_ok,
    input  logic [1:0]        xmit_mode,
    input  logic              carrier_in,
    input  logic              rm_ins,
    input  logic              rm_del,
    output logic              receiving,
    output logic              rx_dv,
    output logic              rx_er,
    output logic [BYTE_W-1:0] rxd,
    output logic              ind_cfg,
    output logic              ind_idle,
    output logic              ind_invalid,
    output logic [CFG_W-1:0]  cfg_reg
);
    logic [BUND_W-1:0] bund_in, bund_d;
    logic [BYTE_W-1:0] cg_d;
    logic [1:0]        xm_d;
    logic k_d, err_d, even_d, car_d, ins_d, del_d;
    logic comma, cfg_char, sof, data_ok, valid, load_lo, load_hi;

    assign bund_in = {rx_byte, rx_ctrl, rx_code_err, rx_even, carrier_in,
                      rm_ins, rm_del, xmit_mode};
    assign {cg_d, k_d, err_d, even_d, car_d, ins_d, del_d, xm_d} = bund_d;

    rxsm_lag #(.LAG(SYNC_LAG), .W(BUND_W)) u_lag (
        .clk(clk), .rst_n(rst_n), .d_in(bund_in), .d_out(bund_d));

    rxsm_classify u_cls (
        .cg(cg_d), .is_k(k_d), .err(err_d), .comma(comma), .cfg_char(cfg_char),
        .sof(sof), .data_ok(data_ok), .valid(valid));

    rxsm_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .sync_ok(sync_ok), .xmit(xmit_e'(xm_d)),
        .even(even_d), .carrier(car_d), .ins(ins_d), .del(del_d),
        .comma(comma), .cfg_char(cfg_char), .sof(sof), .data_ok(data_ok),
        .valid(valid), .load_lo(load_lo), .load_hi(load_hi),
        .receiving(receiving), .rx_dv(rx_dv), .rx_er(rx_er), .rxd(rxd),
        .ind_cfg(ind_cfg), .ind_idle(ind_idle), .ind_invalid(ind_invalid));

    rxsm_cfg_capture u_cap (
        .clk(clk), .rst_n(rst_n), .cg(cg_d), .load_lo(load_lo),
        .load_hi(load_hi), .cfg_word(cfg_reg));

    // R4: the configuration word moves only in the cycle a set completes.
    a_r4_cfg_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !ind_cfg |-> $stable(cfg_reg));
    // R8: at most one receive indication at a time.
    a_r8_ind_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ind_cfg, ind_idle, ind_invalid}));
endmodule

// File: tb/rx_cfg_idle_fsm_tb.sv
`timescale 1ns/1ps
module rx_cfg_idle_fsm_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic rx_ctrl = 1'b0, rx_code_err = 1'b0, rx_even = 1'b0, sync_ok = 1'b1;
    logic [1:0] xmit_mode = 2'd0;
    logic carrier_in = 1'b0, rm_ins = 1'b0, rm_del = 1'b0;
    logic receiving, rx_dv, rx_er, ind_cfg, ind_idle, ind_invalid;
    logic [7:0] rxd;
    logic [15:0] cfg_reg;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    localparam logic [7:0] K = 8'hBC, D215 = 8'hB5, D22 = 8'h42, D162 = 8'h50, SOF = 8'hFB;

    always #2.5 clk = ~clk;

    rx_cfg_idle_fsm u_dut (
        .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_ctrl(rx_ctrl),
        .rx_code_err(rx_code_err), .rx_even(rx_even), .sync_ok(sync_ok),
        .xmit_mode(xmit_mode), .carrier_in(carrier_in), .rm_ins(rm_ins),
        .rm_del(rm_del), .receiving(receiving), .rx_dv(rx_dv), .rx_er(rx_er),
        .rxd(rxd), .ind_cfg(ind_cfg), .ind_idle(ind_idle),
        .ind_invalid(ind_invalid), .cfg_reg(cfg_reg));

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // Drive one code group at the falling edge, then wait for the next one.
    // Outputs seen afterwards reflect the code group driven one call earlier.
    task automatic put(input logic [7:0] b, input logic k, input logic ev,
                       input logic ins, input logic del, input logic car);
        rx_byte = b; rx_ctrl = k; rx_even = ev;
        rm_ins = ins; rm_del = del; carrier_in = car;
        @(negedge clk);
    endtask

    task automatic pk();              put(K, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0); endtask
    task automatic pd(input logic [7:0] b, input logic ev); put(b, 1'b0, ev, 1'b0, 1'b0, 1'b0); endtask

    task automatic t_reset();
        chk("R1 receiving", {15'd0, receiving}, 16'd0);
        chk("R1 rx_dv/rx_er", {14'd0, rx_dv, rx_er}, 16'd0);
        chk("R1 rxd", {8'd0, rxd}, 16'd0);
        chk("R1 indications", {13'd0, ind_cfg, ind_idle, ind_invalid}, 16'd0);
        chk("R1 cfg_reg", cfg_reg, 16'd0);
    endtask

    task automatic t_config_basic();
        pk(); pd(D162, 0); pk();
        chk("R3 idle set reported", {15'd0, ind_idle}, 16'd1);
        pd(D162, 0);
        chk("R3 idle cleared on comma", {15'd0, ind_idle}, 16'd0);
        pk(); pd(D215, 0); pd(8'h34, 1); pd(8'h12, 0);
        chk("R4 word not yet published", cfg_reg, 16'h0000);
        pk();
        chk("R4 ind_cfg at completion", {15'd0, ind_cfg}, 16'd1);
        chk("R4 word value", cfg_reg, 16'h1234);
    endtask

    task automatic t_insert();
        pd(D22, 0);
        put(K, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        put(D22, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        pd(8'h78, 1);
        chk("R5 inserted pair not invalid", {15'd0, ind_invalid}, 16'd0);
        pd(8'h56, 0); pk();
        chk("R5 set completes after insertion", {15'd0, ind_cfg}, 16'd1);
        chk("R5 word after insertion", cfg_reg, 16'h5678);
    endtask

    task automatic t_delete_cd();
        pd(D215, 0); pd(8'hAA, 1); pd(8'hBB, 0);
        put(8'h11, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        chk("R6 first set word", cfg_reg, 16'hBBAA);
        put(8'h22, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R6 low byte position", {15'd0, ind_cfg}, 16'd0);
        pk();
        chk("R6 truncated set completes", {15'd0, ind_cfg}, 16'd1);
        chk("R6 truncated word", cfg_reg, 16'h2211);
        pd(D162, 0);
        chk("R6 no invalid", {15'd0, ind_invalid}, 16'd0);
    endtask

    task automatic t_delete_idle();
        put(8'h33, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        chk("R7 idle state before edit", {15'd0, ind_idle}, 16'd1);
        put(8'h44, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        pk();
        chk("R7 set after idle completes", {15'd0, ind_cfg}, 16'd1);
        chk("R7 word after idle", cfg_reg, 16'h4433);
    endtask

    task automatic t_invalid_paths();
        pd(D162, 0); pd(8'h33, 1); pd(8'h44, 0);
        chk("R7 unflagged data after idle invalid", {15'd0, ind_invalid}, 16'd1);
        pk();
        chk("R8 stays invalid on data", {15'd0, ind_invalid}, 16'd1);
        pd(D162, 0);
        chk("R8 even comma exits invalid", {15'd0, ind_invalid}, 16'd0);
        put(8'h33, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        pk();
        chk("R7 odd-position deletion invalid", {15'd0, ind_invalid}, 16'd1);
        pd(D162, 0); pk(); pd(D215, 0);
        put(K, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        pk();
        chk("R5 comma without insertion invalid", {15'd0, ind_invalid}, 16'd1);
        pd(D215, 0); pd(8'h01, 1); pd(8'h02, 0);
        put(8'h03, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
        chk("R4 word before bad edit", cfg_reg, 16'h0201);
        pk();
        chk("R6 both flags high invalid", {15'd0, ind_invalid}, 16'd1);
        pd(D162, 0);
        xmit_mode = 2'd1;
        pd(8'h33, 1); pk();
        chk("R8 no invalid indication in idle mode", {15'd0, ind_invalid}, 16'd0);
        xmit_mode = 2'd0;
        pd(D162, 0);
    endtask

    task automatic t_sync();
        pk(); pd(D162, 0);
        sync_ok = 1'b0; pk();
        chk("R11 late sync drop hits earlier byte", {15'd0, ind_idle}, 16'd0);
        sync_ok = 1'b1; pd(D162, 0);
        pk();
        chk("R2 no tracking before comma", {15'd0, ind_idle}, 16'd0);
        pd(D162, 0);
        chk("R2 waiting for comma", {15'd0, ind_idle}, 16'd0);
        pk();
        chk("R2 tracking resumes", {15'd0, ind_idle}, 16'd1);
    endtask

    task automatic t_data();
        xmit_mode = 2'd2;
        pd(D162, 0);
        put(SOF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        pd(8'h55, 0);
        chk("R9 start of packet flags", {13'd0, receiving, rx_dv, rx_er}, 16'b110);
        chk("R9 preamble byte", {8'd0, rxd}, 16'h0055);
        pd(8'h55, 1);
        chk("R9 single cycle", {14'd0, receiving, rx_dv}, 16'd0);
        pk(); pd(D162, 0);
        put(8'h12, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
        pd(8'h00, 0);
        chk("R10 judgement cycle", {13'd0, receiving, rx_dv, rx_er}, 16'b100);
        pk();
        chk("R10 false carrier flags", {14'd0, receiving, rx_er}, 16'b11);
        chk("R10 false carrier byte", {8'd0, rxd}, 16'h000E);
        pd(D162, 0);
        chk("R10 error lasts one cycle", {15'd0, rx_er}, 16'd0);
        put(8'h12, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        pd(D162, 0);
        chk("R9 no carrier no reception", {14'd0, receiving, ind_idle}, 16'd0);
        pk();
        chk("R9 comma tracking after no carrier", {15'd0, ind_idle}, 16'd1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_config_basic();
        t_insert();
        t_delete_cd();
        t_delete_idle();
        t_invalid_paths();
        t_sync();
        t_data();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule